// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside an Ethernet receive datapath and makes the keep-or-drop decision for every incoming frame from its 48-bit destination address alone. As the first six bytes of a frame stream past, it stores them and runs a CRC-32 over them. Once the sixth byte has arrived it combines the address, the CRC-derived hash bin and a set of filter mode bits into one accept flag. The flag stays put until the next frame begins.

Three mode bits can be set in any combination. `mode_promisc` takes every frame. `mode_all_mc` takes every multicast frame. `mode_hash_mc` takes a multicast frame when its bin in a 64-entry hash table is set. Unicast frames always need an exact match with the programmed station address, and the broadcast address is always taken. Software can get the same effect as pass-all-multicast by filling both hash words with ones.

Top module: `rx_dst_filter`

## Requirements
- R1: With `mode_hash_mc` set and the other two modes clear, a non-broadcast multicast frame is accepted exactly when its hash bin is 1. The bin index is CRC bits [31:26]. Index bit 5 picks the word (1 = `hash_hi`, 0 = `hash_lo`), and index bits [4:0] pick the bit inside that word.
- R2: The CRC uses polynomial 0x04C11DB7 and starts at 32'hFFFFFFFF. It covers the six destination bytes in arrival order, each byte least significant bit first, shifting left and feeding in at bit 31. The result is not inverted.
- R3: With `mode_promisc` set, every frame is accepted.
- R4: With `mode_all_mc` set, every multicast frame is accepted. With only `mode_hash_mc` set and both hash words all ones, every multicast frame is also accepted.
- R5: A unicast frame (bit 0 of the first destination byte is 0) is accepted only if all 48 bits match the station address, unless `mode_promisc` is set.
- R6: With no mode bit set, a multicast frame that is not broadcast is rejected.
- R7: The destination FF:FF:FF:FF:FF:FF is accepted in every mode.
- R8: `accept_vld` rises in the clock cycle after the edge that takes the sixth destination byte. Idle cycles (`byte_vld` low) between bytes are allowed, and `accept_vld` stays 0 before the sixth byte.
- R9: `accept_vld` and `accept` hold their values until the edge that takes the next start-of-frame byte, which clears `accept_vld`. Bytes after the sixth have no effect.
- R10: The mode bits are sampled with the start-of-frame byte. Changing them later in the frame does not change that frame's result.
- R11: After reset, `accept_vld` and `accept` are 0.
- R12: Destination byte k (0 = first received) is compared with `sta_lo[8k+7:8k]` for k < 4, and with `sta_hi[8(k-4)+7:8(k-4)]` for k = 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Marks the first destination byte; qualified by `byte_vld` |
| byte_vld | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| sta_lo | input | 32 | Station address bytes 0 to 3 |
| sta_hi | input | 16 | Station address bytes 4 and 5 |
| hash_lo | input | 32 | Hash bins 0 to 31 |
| hash_hi | input | 32 | Hash bins 32 to 63 |
| mode_promisc | input | 1 | Accept all frames |
| mode_all_mc | input | 1 | Accept all multicast frames |
| mode_hash_mc | input | 1 | Accept multicast frames whose hash bin is set |
| accept | output | 1 | Decision for the current frame, valid while `accept_vld` |
| accept_vld | output | 1 | Decision available |

## Verification
Only one result has timing: the decision, which is registered on the same edge that takes the sixth byte and read at the next falling edge. The bench drives bytes on falling edges. It confirms that `accept_vld` is still low just before the sixth byte and after every start-of-frame edge. It then checks the flag and its value in the half cycle after the sixth byte, and checks again after extra trailing bytes to confirm the value is held. Expected hash bins come from a bench-side CRC written from R2.

// File: rtl/rx_dst_filter_pkg.sv
// Package: shared constants and the mode record for the destination filter.
package rx_dst_filter_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Filter modes latched at start-of-frame
    typedef struct packed {
        logic promisc;
        logic all_mc;
        logic hash_mc;
    } filt_mode_t;

endpackage

// File: rtl/rdf_crc_step.sv
// Module: rdf_crc_step
// Advances a CRC-32 (left-shifting, no reflection of the register) by one
// byte taken least significant bit first. Purely combinational.
// Assumes the caller supplies the seed for the first byte.
module rdf_crc_step
    import rx_dst_filter_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 32
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // Bit-serial update unrolled over the byte
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < DATA_W; b++) begin
            fb = c[CRC_W-1] ^ data_in[b];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY[CRC_W-1:0];
        end
        crc_out = c;
    end

endmodule

// File: rtl/rdf_addr_capture.sv
// Module: rdf_addr_capture
// Gathers the destination address bytes of a frame and runs the CRC over
// them. Exposes the address and CRC including the byte on the input this
// cycle, plus a strobe for the cycle in which the last address byte arrives.
// Assumes sof is only meaningful together with byte_vld and ADDR_BYTES > 1.
module rdf_addr_capture
    import rx_dst_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int DATA_W     = 8,
    parameter int CRC_W      = 32,
    localparam int ADDR_W    = ADDR_BYTES * DATA_W,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    output logic [ADDR_W-1:0] addr_now,
    output logic [CRC_W-1:0]  crc_now,
    output logic              addr_done
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CNT_W-1:0]  pos;
    logic [CRC_W-1:0]  crc_base;
    logic [CRC_W-1:0]  crc_stepped;
    logic              take;

    assign pos      = sof ? '0 : cnt_q;
    assign take     = byte_vld && (sof || (cnt_q < CNT_FULL));
    assign crc_base = sof ? CRC_SEED[CRC_W-1:0] : crc_q;

    rdf_crc_step #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W)
    ) u_crc (
        .crc_in  (crc_base),
        .data_in (byte_data),
        .crc_out (crc_stepped)
    );

    // Overlay the incoming byte onto the stored address
    always_comb begin
        addr_now = addr_q;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (take && (pos == CNT_W'(i))) addr_now[i*DATA_W +: DATA_W] = byte_data;
        end
    end

    assign crc_now   = take ? crc_stepped : crc_q;
    assign addr_done = byte_vld && !sof && (cnt_q == CNT_LAST);

    // Byte counter, address store and running CRC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_FULL;
            addr_q <= '0;
            crc_q  <= CRC_SEED[CRC_W-1:0];
        end else if (take) begin
            cnt_q  <= pos + 1'b1;
            addr_q <= addr_now;
            crc_q  <= crc_stepped;
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    p_sof_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && byte_vld) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/rdf_decide.sv
// Module: rdf_decide
// Combinational accept rule: promiscuous, broadcast, multicast by mode or
// hash bin, unicast by exact station match. Assumes the address is laid
// out with the first received byte in the lowest byte lane.
module rdf_decide
    import rx_dst_filter_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int CRC_W   = 32,
    parameter int HASH_W  = 6,
    localparam int WORD_W = 1 << (HASH_W - 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CRC_W-1:0]  crc,
    input  logic [ADDR_W-1:0] station,
    input  logic [WORD_W-1:0] hash_lo,
    input  logic [WORD_W-1:0] hash_hi,
    input  filt_mode_t        mode,
    output logic              accept
);

    logic [HASH_W-1:0] idx;
    logic              bin;
    logic              is_mc;
    logic              is_bc;
    logic              is_mine;

    assign idx     = crc[CRC_W-1 -: HASH_W];
    assign bin     = idx[HASH_W-1] ? hash_hi[idx[HASH_W-2:0]] : hash_lo[idx[HASH_W-2:0]];
    assign is_mc   = addr[0];
    assign is_bc   = &addr;
    assign is_mine = (addr == station);

    // Combine the mode bits into one decision
    always_comb begin
        if (mode.promisc || is_bc)
            accept = 1'b1;
        else if (is_mc)
            accept = mode.all_mc || (mode.hash_mc && bin);
        else
            accept = is_mine;
    end

    // R6: with no multicast mode, a non-broadcast multicast address is refused
    always_comb begin
        if (!mode.promisc && !mode.all_mc && !mode.hash_mc && is_mc && !is_bc)
            p_no_mc_reject_r6: assert (!accept);
    end

endmodule

// File: rtl/rx_dst_filter.sv
// Module: rx_dst_filter (top)
// Receive destination address filter. Latches the mode bits with the
// start-of-frame byte, collects the destination address with its CRC, and
// registers one accept decision per frame, held until the next frame.
// Assumes station and hash inputs are stable while a frame's address arrives.
module rx_dst_filter
    import rx_dst_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int DATA_W     = 8,
    parameter int HASH_W     = 6,
    parameter int STA_LO_W   = 32,
    localparam int ADDR_W    = ADDR_BYTES * DATA_W,
    localparam int STA_HI_W  = ADDR_W - STA_LO_W,
    localparam int WORD_W    = 1 << (HASH_W - 1),
    localparam int CRC_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof,
    input  logic                byte_vld,
    input  logic [DATA_W-1:0]   byte_data,
    input  logic [STA_LO_W-1:0] sta_lo,
    input  logic [STA_HI_W-1:0] sta_hi,
    input  logic [WORD_W-1:0]   hash_lo,
    input  logic [WORD_W-1:0]   hash_hi,
    input  logic                mode_promisc,
    input  logic                mode_all_mc,
    input  logic                mode_hash_mc,
    output logic                accept,
    output logic                accept_vld
);

    filt_mode_t        mode_q;
    logic [ADDR_W-1:0] addr_now;
    logic [CRC_W-1:0]  crc_now;
    logic              addr_done;
    logic              verdict;
    logic              frame_start;

    assign frame_start = sof && byte_vld;

    // Sample the filter modes with the first byte of each frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (frame_start)
            mode_q <= '{promisc: mode_promisc, all_mc: mode_all_mc, hash_mc: mode_hash_mc};
    end

    rdf_addr_capture #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_W     (DATA_W),
        .CRC_W      (CRC_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .addr_now  (addr_now),
        .crc_now   (crc_now),
        .addr_done (addr_done)
    );

    rdf_decide #(
        .ADDR_W (ADDR_W),
        .CRC_W  (CRC_W),
        .HASH_W (HASH_W)
    ) u_decide (
        .addr    (addr_now),
        .crc     (crc_now),
        .station ({sta_hi, sta_lo}),
        .hash_lo (hash_lo),
        .hash_hi (hash_hi),
        .mode    (mode_q),
        .accept  (verdict)
    );

    // Register the decision and hold it until the next frame starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept     <= 1'b0;
            accept_vld <= 1'b0;
        end else if (frame_start) begin
            accept_vld <= 1'b0;
        end else if (addr_done) begin
            accept     <= verdict;
            accept_vld <= 1'b1;
        end
    end

    p_vld_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_vld) |-> $past(addr_done));

    p_sof_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !accept_vld);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_vld && !frame_start) |=> (accept_vld && $stable(accept)));

    p_promisc_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_vld && mode_q.promisc) |-> accept);

    p_bcast_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(accept_vld) && $past(&addr_now)) |-> accept);

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode_q));

endmodule

// File: tb/rx_dst_filter_tb.sv
module rx_dst_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sof;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic [31:0] sta_lo;
    logic [15:0] sta_hi;
    logic [31:0] hash_lo;
    logic [31:0] hash_hi;
    logic        mode_promisc;
    logic        mode_all_mc;
    logic        mode_hash_mc;
    logic        accept;
    logic        accept_vld;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    localparam logic [47:0] STA = 48'hAB_CD_EF_12_34_02;

    always #2.5 clk = ~clk;

    rx_dst_filter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof          (sof),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .sta_lo       (sta_lo),
        .sta_hi       (sta_hi),
        .hash_lo      (hash_lo),
        .hash_hi      (hash_hi),
        .mode_promisc (mode_promisc),
        .mode_all_mc  (mode_all_mc),
        .mode_hash_mc (mode_hash_mc),
        .accept       (accept),
        .accept_vld   (accept_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 written out: CRC over the six address bytes
    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[31] ^ a[8*i + b];
                c  = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    function automatic bit ref_accept(input logic [47:0] a, input bit pr, input bit am, input bit hs);
        logic [5:0] idx;
        bit         bin;
        idx = ref_crc(a) >> 26;
        bin = idx[5] ? hash_hi[idx[4:0]] : hash_lo[idx[4:0]];
        if (pr || (&a)) return 1'b1;
        if (a[0]) return am || (hs && bin);
        return a == STA;
    endfunction

    // Send one destination address; optional gaps, mid-frame mode flip, trailing bytes
    task automatic send_frame(input logic [47:0] a, input int gap, input bit flip,
                              input int extra, input string req);
        bit pr = mode_promisc, am = mode_all_mc, hs = mode_hash_mc;
        bit exp;
        exp = ref_accept(a, pr, am, hs);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) check(accept_vld == 1'b0, "R9 vld cleared by sof", int'(accept_vld), 0);
            if (i == 5) check(accept_vld == 1'b0, "R8 vld low before sixth byte", int'(accept_vld), 0);
            if (i == 1 && flip) begin
                mode_promisc = ~pr; mode_all_mc = ~am; mode_hash_mc = ~hs;
            end
            sof = (i == 0); byte_vld = 1'b1; byte_data = a[8*i +: 8];
            for (int g = 0; g < gap && i < 5; g++) begin
                @(negedge clk);
                sof = 1'b0; byte_vld = 1'b0; byte_data = 8'hEE;
            end
        end
        @(negedge clk);
        sof = 1'b0; byte_vld = 1'b0;
        check(accept_vld == 1'b1, {req, " (R8 vld)"}, int'(accept_vld), 1);
        check(accept == exp, req, int'(accept), int'(exp));
        for (int e = 0; e < extra; e++) begin
            byte_vld = 1'b1; byte_data = ~a[7:0] ^ 8'(e);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        if (extra > 0) begin
            check(accept_vld == 1'b1, "R9 vld held after trailing bytes", int'(accept_vld), 1);
            check(accept == exp, "R9 value held after trailing bytes", int'(accept), int'(exp));
        end
        mode_promisc = pr; mode_all_mc = am; mode_hash_mc = hs;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [47:0] addrs[16];
        rst_n = 1'b0; sof = 1'b0; byte_vld = 1'b0; byte_data = '0;
        sta_lo = STA[31:0]; sta_hi = STA[47:32];
        hash_lo = 32'hA5A5_0F0F; hash_hi = 32'h3C3C_F00F;
        mode_promisc = 0; mode_all_mc = 0; mode_hash_mc = 0;
        repeat (3) @(negedge clk);
        check(accept_vld == 1'b0, "R11 reset vld", int'(accept_vld), 0);
        check(accept == 1'b0, "R11 reset accept", int'(accept), 0);
        rst_n = 1'b1;

        // Address classes: exact match, one-byte mismatches (R12), broadcast, multicasts
        addrs[0] = STA;
        for (int k = 0; k < 6; k++) addrs[1 + k] = STA ^ (48'h10 << (8 * k));
        addrs[7] = 48'hFFFF_FFFF_FFFF;
        for (int k = 0; k < 8; k++) addrs[8 + k] = {8'(k * 37 + 3), 8'h5E, 8'h11, 8'h22, 8'h00, 8'h01};

        // Sweep all mode combinations over every class (R3..R7, R12, R1)
        for (int m = 0; m < 8; m++) begin
            mode_promisc = m[0]; mode_all_mc = m[1]; mode_hash_mc = m[2];
            for (int j = 0; j < 16; j++) begin
                send_frame(addrs[j], 0, 1'b0, 0,
                    (m[0] ? "R3 promiscuous" :
                     j == 7 ? "R7 broadcast" :
                     j < 7 ? "R5 R12 unicast match" :
                     m[1] ? "R4 all multicast" :
                     m[2] ? "R1 hash bin" : "R6 multicast rejected"));
            end
        end

        // Hash sweep over 64 multicast addresses with two tables (R1, R2)
        mode_promisc = 0; mode_all_mc = 0; mode_hash_mc = 1;
        for (int t = 0; t < 2; t++) begin
            if (t == 1) begin hash_lo = 32'h0123_4567; hash_hi = 32'hFEDC_BA98; end
            for (int k = 0; k < 64; k++)
                send_frame({8'(k), 8'(k * 5), 24'h00005E, 8'h01}, 0, 1'b0, 0, "R1 R2 hash index");
        end

        // All-ones table equals pass-all-multicast (R4)
        hash_lo = '1; hash_hi = '1;
        for (int k = 0; k < 16; k++)
            send_frame({8'(k * 11), 32'h1234_5600, 8'h03}, 0, 1'b0, 0, "R4 all-ones table");

        // Gaps between bytes, trailing bytes, mid-frame mode change (R8, R9, R10)
        hash_lo = 32'hA5A5_0F0F; hash_hi = 32'h3C3C_F00F;
        mode_promisc = 0; mode_all_mc = 0; mode_hash_mc = 0;
        send_frame(STA, 2, 1'b0, 3, "R8 gapped unicast");
        send_frame(addrs[3], 3, 1'b0, 2, "R8 gapped mismatch");
        send_frame(addrs[3], 0, 1'b1, 0, "R10 promisc set mid-frame ignored");
        mode_promisc = 1;
        send_frame(addrs[3], 1, 1'b1, 2, "R10 promisc cleared mid-frame ignored");
        mode_promisc = 0; mode_all_mc = 1;
        send_frame(addrs[9], 0, 1'b1, 0, "R10 all-mc cleared mid-frame ignored");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule